// File: doc/BRIEF.md
# Bus Fence Sequencer

This block puts a fence around the bus port of one or more power domains before they are switched off, and removes the fence after they come back. It holds two per-domain state vectors. The fence-enable vector goes to the interconnect's fencing logic. The temporary clock-enable vector keeps the fence logic clocked while the fence moves. Each bit of each vector changes only through a write-one-to-set or write-one-to-clear strobe. Bits outside a request's mask therefore never move.

A power controller sends a request with a domain mask and an operation: raise the fence or drop it. The block then runs a fixed sequence. It switches the masked clock enables on, then it moves the fence bits. On a raise, it waits until the interconnect shows every masked fence as settled. Last, it switches the clock enables off again and reports completion. If the settle wait runs past its limit, the block reports a timeout. In that case it leaves the clock enables on, so the power controller can see where the sequence stopped.

Requests use a ready/valid handshake. The block runs one request at a time and holds the next one off until the current one completes.

Top module: `bus_prot_seq`

## Requirements
- R1: After reset, `fence_en_o` and `clkgate_en_o` are all zeros, `req_ready_o` is 1, and `done_o` and `done_err_o` are 0.
- R2: A request is accepted on a clock edge where `req_valid_i` and `req_ready_o` are both 1. One cycle after acceptance, every masked bit of `clkgate_en_o` is 1 and `fence_en_o` is unchanged.
- R3: For a raise request (`req_raise_i`=1), the masked `fence_en_o` bits become 1 two cycles after acceptance. The block then samples `fence_rdy_i` once per cycle, starting at the third edge after acceptance. If the k-th such sample has all masked bits at 1 (k ≥ 1), completion is reported 3+k cycles after acceptance.
- R4: For a drop request (`req_raise_i`=0), the masked `fence_en_o` bits become 0 two cycles after acceptance. Completion is reported three cycles after acceptance, whatever the value of `fence_rdy_i`.
- R5: On a completion without error, the masked `clkgate_en_o` bits return to 0 in the same cycle that `done_o` is 1 with `done_err_o`=0.
- R6: No request changes any `fence_en_o` or `clkgate_en_o` bit outside its mask.
- R7: If TMO_CYC consecutive samples of a raise request all miss at least one masked ready bit, the block reports completion with `done_err_o`=1 at 3+TMO_CYC cycles after acceptance. The masked `clkgate_en_o` and `fence_en_o` bits stay at 1. With the default TMO_CYC of 25000 at a 50 MHz clock, this limit is 500 µs.
- R8: `req_ready_o` is 0 from the cycle after acceptance until `done_o` is 1. Requests presented during that time are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_mask_i | input | NDOM | Domains addressed by the request |
| req_raise_i | input | 1 | 1 = raise fence, 0 = drop fence |
| fence_rdy_i | input | NDOM | Per-domain fence-settled status from the interconnect |
| fence_en_o | output | NDOM | Per-domain fence enable |
| clkgate_en_o | output | NDOM | Per-domain temporary clock enable for the fence logic |
| done_o | output | 1 | One-cycle completion pulse |
| done_err_o | output | 1 | With `done_o`: the settle wait timed out |

## Verification
The clock enable is due one cycle after acceptance and the fence change two cycles after. A drop completes three cycles after acceptance. A raise completes 3+k cycles after acceptance, where k is the first settled sample, or 3+TMO_CYC cycles after acceptance on a timeout. The bench counts falling edges from the acceptance edge and checks each value at exactly that count. It also sets each ready input at a known falling edge, so the expected completion cycle can be worked out before the run. A behavioural model advances on the same rising edges and is compared with every output on each falling edge, so any early or late change shows up in the cycle it happens.

// File: rtl/bpc_pkg.sv
package bpc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CG_ON  = 3'd1,
    ST_MOVE   = 3'd2,
    ST_SETTLE = 3'd3,
    ST_CG_OFF = 3'd4,
    ST_FAIL   = 3'd5
  } bpc_state_e;

  localparam int MAX_DOM = 64;

  // True when every bit selected by msk is high in sta.
  function automatic logic all_covered(input logic [MAX_DOM-1:0] sta,
                                       input logic [MAX_DOM-1:0] msk);
    return (sta & msk) == msk;
  endfunction

  // Next value of a set/clear register; set wins over clear.
  function automatic logic [MAX_DOM-1:0] w1sc_next(input logic [MAX_DOM-1:0] q,
                                                   input logic [MAX_DOM-1:0] set_b,
                                                   input logic [MAX_DOM-1:0] clr_b);
    return (q & ~clr_b) | set_b;
  endfunction

endpackage

// File: rtl/bpc_w1sc_reg.sv
module bpc_w1sc_reg
  import bpc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0]       q_r;
  logic [MAX_DOM-1:0] nxt_wide;

  always_comb begin
    nxt_wide = w1sc_next(MAX_DOM'(q_r), MAX_DOM'(set_i), MAX_DOM'(clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= nxt_wide[W-1:0];
  end

  assign q_o = q_r;

endmodule

// File: rtl/bpc_wait_timer.sv
module bpc_wait_timer #(
  parameter int LIMIT = 25000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);

  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

endmodule

// File: rtl/bpc_seq_fsm.sv
module bpc_seq_fsm
  import bpc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid_i,
  output logic         req_ready_o,
  input  logic [W-1:0] req_mask_i,
  input  logic         req_raise_i,
  input  logic         rdy_all_i,
  input  logic         tmo_i,
  output logic [W-1:0] act_mask_o,
  output logic         settle_o,
  output logic [W-1:0] cg_set_o,
  output logic [W-1:0] cg_clr_o,
  output logic [W-1:0] fence_set_o,
  output logic [W-1:0] fence_clr_o,
  output logic         done_o,
  output logic         err_o
);

  bpc_state_e   st_q, st_d;
  logic [W-1:0] mask_q;
  logic         raise_q;
  logic         done_q, err_q;
  logic         take;

  assign take = req_valid_i && (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (take) st_d = ST_CG_ON;
      ST_CG_ON:  st_d = ST_MOVE;
      ST_MOVE:   st_d = raise_q ? ST_SETTLE : ST_CG_OFF;
      ST_SETTLE: begin
        if (rdy_all_i)  st_d = ST_CG_OFF;
        else if (tmo_i) st_d = ST_FAIL;
      end
      ST_CG_OFF: st_d = ST_IDLE;
      ST_FAIL:   st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mask_q  <= '0;
      raise_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_CG_OFF) || (st_q == ST_FAIL);
      err_q  <= (st_q == ST_FAIL);
      if (take) begin
        mask_q  <= req_mask_i;
        raise_q <= req_raise_i;
      end
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign act_mask_o  = mask_q;
  assign settle_o    = (st_q == ST_SETTLE);
  assign cg_set_o    = (st_q == ST_CG_ON)              ? mask_q : '0;
  assign cg_clr_o    = (st_q == ST_CG_OFF)             ? mask_q : '0;
  assign fence_set_o = (st_q == ST_MOVE &&  raise_q)   ? mask_q : '0;
  assign fence_clr_o = (st_q == ST_MOVE && !raise_q)   ? mask_q : '0;
  assign done_o      = done_q;
  assign err_o       = err_q;

endmodule

// File: rtl/bus_prot_seq.sv
module bus_prot_seq
  import bpc_pkg::*;
#(
  parameter int NDOM    = 8,
  parameter int TMO_CYC = 25000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [NDOM-1:0] req_mask_i,
  input  logic            req_raise_i,
  input  logic [NDOM-1:0] fence_rdy_i,
  output logic [NDOM-1:0] fence_en_o,
  output logic [NDOM-1:0] clkgate_en_o,
  output logic            done_o,
  output logic            done_err_o
);

  // Internal events brought out by name for the checker.
  logic [NDOM-1:0] act_mask;
  logic            settle_active;
  logic            tmo_hit;
  logic            rdy_all;

  logic [NDOM-1:0] cg_set, cg_clr, fence_set, fence_clr;

  assign rdy_all = all_covered(MAX_DOM'(fence_rdy_i), MAX_DOM'(act_mask));

  bpc_seq_fsm #(.W(NDOM)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_mask_i  (req_mask_i),
    .req_raise_i (req_raise_i),
    .rdy_all_i   (rdy_all),
    .tmo_i       (tmo_hit),
    .act_mask_o  (act_mask),
    .settle_o    (settle_active),
    .cg_set_o    (cg_set),
    .cg_clr_o    (cg_clr),
    .fence_set_o (fence_set),
    .fence_clr_o (fence_clr),
    .done_o      (done_o),
    .err_o       (done_err_o)
  );

  bpc_wait_timer #(.LIMIT(TMO_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (settle_active),
    .expire_o (tmo_hit)
  );

  bpc_w1sc_reg #(.W(NDOM)) u_cg_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (cg_set),
    .clr_i (cg_clr),
    .q_o   (clkgate_en_o)
  );

  bpc_w1sc_reg #(.W(NDOM)) u_fence_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (fence_set),
    .clr_i (fence_clr),
    .q_o   (fence_en_o)
  );

endmodule

// File: rtl/bpc_checker.sv
module bpc_checker #(
  parameter int NDOM    = 8,
  parameter int TMO_CYC = 25000
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            req_raise_i,
  input logic [NDOM-1:0] fence_rdy_i,
  input logic [NDOM-1:0] fence_en_o,
  input logic [NDOM-1:0] clkgate_en_o,
  input logic            done_o,
  input logic            done_err_o,
  input logic [NDOM-1:0] act_mask,
  input logic            settle_active,
  input logic            tmo_hit,
  input logic            rdy_all
);

  int wcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             wcnt <= 0;
    else if (settle_active) wcnt <= wcnt + 1;
    else                    wcnt <= 0;
  end

  AST_CG_WRAPS_FENCE: assert property (@(posedge clk) disable iff (!rst_n)
    ((fence_en_o ^ $past(fence_en_o)) & ~(clkgate_en_o & $past(clkgate_en_o))) == '0); // R2

  AST_SETTLE_EXITS_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_active && rdy_all) |=> !settle_active); // R3

  AST_SETTLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (settle_active && !rdy_all && !tmo_hit) |=> settle_active); // R3

  AST_READY_MATCHES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_all |-> ((fence_rdy_i & act_mask) == act_mask)); // R3

  AST_DROP_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && !req_raise_i) |-> ##4 (done_o && !done_err_o)); // R4

  AST_CG_OFF_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(clkgate_en_o) & ~clkgate_en_o) != '0) |-> (done_o && !done_err_o)); // R5

  AST_FENCE_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((fence_en_o ^ $past(fence_en_o)) & ~act_mask) == '0); // R6

  AST_CG_IN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ((clkgate_en_o ^ $past(clkgate_en_o)) & ~act_mask) == '0); // R6

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_err_o |-> done_o); // R7

  AST_ERR_ONLY_UNSETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    done_err_o |-> $past(settle_active && !rdy_all, 2)); // R7

  AST_ERR_KEEPS_CG: assert property (@(posedge clk) disable iff (!rst_n)
    done_err_o |-> ((clkgate_en_o & act_mask) == act_mask)); // R7

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= TMO_CYC); // R7

  AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o) |=> !req_ready_o); // R8

  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> req_ready_o); // R8

endmodule

bind bus_prot_seq bpc_checker #(.NDOM(NDOM), .TMO_CYC(TMO_CYC)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid_i   (req_valid_i),
  .req_ready_o   (req_ready_o),
  .req_raise_i   (req_raise_i),
  .fence_rdy_i   (fence_rdy_i),
  .fence_en_o    (fence_en_o),
  .clkgate_en_o  (clkgate_en_o),
  .done_o        (done_o),
  .done_err_o    (done_err_o),
  .act_mask      (act_mask),
  .settle_active (settle_active),
  .tmo_hit       (tmo_hit),
  .rdy_all       (rdy_all)
);

// File: tb/sim_bus_prot_seq.sv
module sim_bus_prot_seq;

  localparam int N = 8;
  localparam int T = 40;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_raise = 1'b0;
  logic [N-1:0] req_mask = '0;
  logic [N-1:0] fence_rdy = '0;
  logic         req_ready, done, err;
  logic [N-1:0] fence, cg;

  int errs = 0;
  int chks = 0;

  always #10 clk = ~clk;

  bus_prot_seq #(.NDOM(N), .TMO_CYC(T)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .req_mask_i   (req_mask),
    .req_raise_i  (req_raise),
    .fence_rdy_i  (fence_rdy),
    .fence_en_o   (fence),
    .clkgate_en_o (cg),
    .done_o       (done),
    .done_err_o   (err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference: step counts the phases of the running request.
  bit           m_busy = 0, m_raise = 0, m_done = 0, m_err = 0;
  int           m_step = 0, m_wait = 0;
  logic [N-1:0] m_mask = '0, m_fence = '0, m_cg = '0;

  always @(posedge clk) begin
    m_done = 0;
    m_err  = 0;
    if (!rst_n) begin
      m_busy = 0; m_step = 0; m_fence = '0; m_cg = '0;
    end else if (!m_busy) begin
      if (req_valid) begin
        m_busy = 1; m_step = 1; m_mask = req_mask; m_raise = req_raise;
      end
    end else begin
      case (m_step)
        1: begin m_cg = m_cg | m_mask; m_step = 2; end
        2: begin
          if (m_raise) m_fence = m_fence | m_mask;
          else         m_fence = m_fence & ~m_mask;
          m_step = m_raise ? 3 : 4;
          m_wait = 0;
        end
        3: begin
          if ((fence_rdy & m_mask) == m_mask) m_step = 4;
          else begin
            m_wait++;
            if (m_wait == T) m_step = 5;
          end
        end
        4: begin m_cg = m_cg & ~m_mask; m_done = 1; m_busy = 0; m_step = 0; end
        default: begin m_done = 1; m_err = 1; m_busy = 0; m_step = 0; end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cg == m_cg, "R5 per-cycle clock-enable vector", cg, m_cg);
      chk(fence == m_fence, "R6 per-cycle fence vector", fence, m_fence);
      chk(req_ready == !m_busy, "R8 per-cycle ready", req_ready, !m_busy);
      chk({done, err} == {m_done, m_err}, "R7 per-cycle completion", {done, err}, {m_done, m_err});
    end
  end

  task automatic run_op(input logic [N-1:0] m, input bit raise, input int rise_at,
                        input logic [N-1:0] rdy_after, input bit poke,
                        output int n, output bit e);
    logic [N-1:0] f0;
    while (!req_ready) @(negedge clk);
    f0 = fence;
    req_valid = 1'b1; req_mask = m; req_raise = raise;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; e = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == rise_at) fence_rdy = rdy_after;
      if (n == 1)
        chk(((cg & m) == m) && (fence == f0), "R2 clock enable first, fence unchanged", {cg, fence}, {m, f0});
      if (n == 2 && raise)
        chk((fence & m) == m, "R3 fence raised two cycles after take", fence, f0 | m);
      if (n == 2 && !raise)
        chk((fence & m) == '0, "R4 fence dropped two cycles after take", fence, f0 & ~m);
      if (poke) begin
        if (n == 3) begin req_valid = 1'b1; req_mask = 8'h80; req_raise = 1'b1; end
        if (n == 5) chk(req_ready == 1'b0, "R8 held off while busy", req_ready, 0);
        if (n == 6) req_valid = 1'b0;
      end
      if (done) begin e = err; break; end
    end
  endtask

  initial begin
    int n;
    bit e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fence == '0, "R1 fence reset", fence, 0);
    chk(cg == '0, "R1 clock enable reset", cg, 0);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(done == 1'b0 && err == 1'b0, "R1 no completion after reset", {done, err}, 0);

    // Raise domain 0 with its ready already high: k = 1.
    fence_rdy = 8'h01;
    run_op(8'h01, 1'b1, 0, '0, 1'b0, n, e);
    chk(n == 4, "R3 raise latency with ready high", n, 4);
    chk(e == 1'b0, "R3 no error", e, 0);
    chk(cg == 8'h00, "R5 clock enable off at done", cg, 0);

    // Raise domain 3, ready rises at count 10 -> done at 12; a second request pokes in.
    run_op(8'h08, 1'b1, 10, 8'h09, 1'b1, n, e);
    chk(n == 12, "R3 raise waits for ready", n, 12);
    chk(e == 1'b0, "R3 no error after late ready", e, 0);
    chk(fence == 8'h09, "R6 domain 0 kept, busy request not taken", fence, 8'h09);

    // Drop domain 0 while its ready is high.
    run_op(8'h01, 1'b0, 0, '0, 1'b0, n, e);
    chk(n == 3, "R4 drop latency", n, 3);
    chk(fence == 8'h08, "R6 drop leaves domain 3", fence, 8'h08);
    chk(cg == 8'h00, "R5 clock enable off after drop", cg, 0);

    // Two-domain raise where domain 5 never settles.
    fence_rdy = 8'h19;
    run_op(8'h30, 1'b1, 0, '0, 1'b0, n, e);
    chk(n == T + 3, "R7 timeout latency", n, T + 3);
    chk(e == 1'b1, "R7 timeout flagged", e, 1);
    chk(cg == 8'h30, "R7 clock enable left on", cg, 8'h30);
    chk(fence == 8'h38, "R7 fence left raised", fence, 8'h38);

    // Retry with both domains settled.
    fence_rdy = 8'h39;
    run_op(8'h30, 1'b1, 0, '0, 1'b0, n, e);
    chk(n == 4 && e == 1'b0, "R3 retry completes", {n[7:0], e}, {8'd4, 1'b0});
    chk(cg == 8'h00, "R5 retry clears clock enables", cg, 0);

    // Drop everything with no ready at all.
    fence_rdy = 8'h00;
    run_op(8'h38, 1'b0, 0, '0, 1'b0, n, e);
    chk(n == 3 && e == 1'b0, "R4 drop ignores ready", {n[7:0], e}, {8'd3, 1'b0});
    chk(fence == 8'h00, "R4 all fences dropped", fence, 0);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    chks++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

endmodule